// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Keyed Write Protection

This block is a watchdog that supervises software through two down-counting stages sitting behind a plain register write/read bus. While enabled, a prescaler produces a slow tick from the bus clock. The first stage counts ticks down from its preload. When it runs out it latches an interrupt status and, unless the interrupt is masked, drives a level interrupt. The second stage then counts down from its own preload. When it also runs out it raises a fixed-width reset pulse, sets a sticky timeout flag and restarts both stages.

Both preload registers and the reload/flag register are guarded by a key: two byte writes to the reload address, 0x80 followed by 0x86, open the guarded set for exactly one write. Configuration (tick rate, interrupt masking, reset-output gating) and control (enable, lock, timer mode) need no key. Once the lock bit is set the watchdog cannot be switched off until a power-on reset. The timeout flag and the lock survive the system reset that the pulse itself would trigger, so software can tell after a restart that the watchdog fired. Only the power-on input clears them.

Register offsets: first-stage preload 0x00, second-stage preload 0x04, interrupt status 0x08, reload/flag 0x0C, configuration 0x10, control 0x14.

Top module: `wdt_dual_stage`

## Requirements
- R1: A write of byte 0x80 and then byte 0x86 (data bits 7:0) to offset 0x0C opens the guarded registers (0x00, 0x04, 0x0C) for the next single write of any address. A write to a guarded register without this key leaves it unchanged.
- R2: After 0x80, a write to any other address, or any byte other than 0x86 to 0x0C, returns the key sequencer to idle, so a following guarded write is ignored.
- R3: A keyed write to 0x0C with bit 8 set reloads both stages from their preloads, clears the prescaler and restarts the first stage.
- R4: Configuration bit 2 selects the tick: 0 gives one tick per 2^15 bus clocks, 1 gives one tick per 2^5 bus clocks.
- R5: The first stage expires on its Nth tick after a reload or enable (a preload of 0 counts as 1). One clock later, bit 0 at 0x08 reads 1 and `irq_o` goes high unless configuration bits 1:0 are 11. Writing 1 to bit 0 of 0x08 clears both.
- R6: The second stage expires on its Mth tick after the first stage expires. One clock later, `wdt_rst_o` is high for exactly 16 bus clocks and the timeout flag is set. Both stages then restart from their preloads.
- R7: With configuration bit 5 set, second-stage expiry does not pulse `wdt_rst_o`, but it still sets the timeout flag.
- R8: The timeout flag reads at bit 9 of 0x0C. A keyed write with bit 9 set clears it. `sys_rst` leaves it untouched, and only `por` clears it.
- R9: Control bit 1 (enable) is written without the key. Control bit 0 (lock) can only be set. While the lock is set, enable cannot be cleared by a write or by `sys_rst`, and reading 0x14 shows that. Only `por` clears the lock.
- R10: While enable is 0, both stages hold their counts and the prescaler stays at zero, so partly elapsed ticks are discarded.
- R11: With control bit 2 set (timer mode), second-stage expiry restarts the stages without a reset pulse and without setting the timeout flag. First-stage expiry behaves as in R5.
- R12: Preload registers are 20 bits wide, and higher write bits are dropped. `rd_data` returns the register at `rd_addr` one clock later. After reset the preloads read 0x200 and all other registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| por | input | 1 | Power-on reset, synchronous, active high; clears everything |
| sys_rst | input | 1 | System reset, synchronous, active high; spares flag, lock, pulse |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | First-stage interrupt level |
| wdt_rst_o | output | 1 | Reset request pulse |

## Verification
A key sequencer left open or stuck shows up at the ports as soon as the next guarded write: the preload readback either changes when it should not or stays at its old value. A counter or prescaler that is off by one shows up in the cycle count from the enable or reload write to the rising edge of `irq_o` or `wdt_rst_o`. The bench compares that count exactly against the tick period times the preload, plus one clock. A lost or cleared sticky bit is seen by reading 0x0C or 0x14 right after a `sys_rst` pulse. An error in the pulse stretcher shows up as a high time on `wdt_rst_o` other than 16 clocks.

// File: rtl/wdt2_pkg.sv
`timescale 1ns/1ps
package wdt2_pkg;
  // Register byte offsets
  localparam logic [7:0] OFS_PRE1   = 8'h00;
  localparam logic [7:0] OFS_PRE2   = 8'h04;
  localparam logic [7:0] OFS_STAT   = 8'h08;
  localparam logic [7:0] OFS_RELOAD = 8'h0C;
  localparam logic [7:0] OFS_CFG    = 8'h10;
  localparam logic [7:0] OFS_CTRL   = 8'h14;

  // Key bytes, in the order they must arrive
  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  // Bit positions
  localparam int RLD_CMD_BIT  = 8;
  localparam int RLD_FLAG_BIT = 9;
  localparam int CFG_NORST    = 5;
  localparam int CFG_FAST     = 2;
  localparam int CTRL_MODE    = 2;
  localparam int CTRL_EN      = 1;
  localparam int CTRL_LOCK    = 0;

  typedef enum logic [1:0] {KS_IDLE, KS_HALF, KS_OPEN} key_state_t;
  typedef enum logic {PH_FIRST, PH_SECOND} phase_t;
endpackage

// File: rtl/wdt2_keyseq.sv
`timescale 1ns/1ps
module wdt2_keyseq
  import wdt2_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_byte,
  output logic              open_o
);
  localparam logic [ADDR_W-1:0] RLD_A = ADDR_W'(OFS_RELOAD);

  key_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= KS_IDLE;
    end else if (wr_en) begin
      unique case (state)
        KS_IDLE: state <= (wr_addr == RLD_A && wr_byte == KEY_FIRST) ? KS_HALF : KS_IDLE;
        KS_HALF: state <= (wr_addr == RLD_A && wr_byte == KEY_SECOND) ? KS_OPEN : KS_IDLE;
        default: state <= KS_IDLE;
      endcase
    end
  end

  assign open_o = (state == KS_OPEN);

  // R1: the open window is consumed by exactly one write
  assert_single_use_R1: assert property (@(posedge clk) disable iff (rst)
    (state == KS_OPEN && wr_en) |=> (state == KS_IDLE));

  // R2: a foreign address after the first key aborts the sequence
  assert_abort_R2: assert property (@(posedge clk) disable iff (rst)
    (state == KS_HALF && wr_en && wr_addr != RLD_A) |=> (state == KS_IDLE));
endmodule

// File: rtl/wdt2_prescale.sv
`timescale 1ns/1ps
module wdt2_prescale #(
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  input  logic fast,
  output logic tick
);
  localparam int PW = SLOW_LOG2;
  localparam logic [PW-1:0] SLOW_LAST = PW'((64'd1 << SLOW_LOG2) - 1);
  localparam logic [PW-1:0] FAST_LAST = PW'((64'd1 << FAST_LOG2) - 1);

  logic [PW-1:0] pc;
  logic [PW-1:0] last;

  assign last = fast ? FAST_LAST : SLOW_LAST;
  assign tick = run && (pc >= last);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) pc <= '0;
    else if (tick)            pc <= '0;
    else                      pc <= pc + 1'b1;
  end

  // R4: ticks are single-cycle and never back to back
  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/wdt2_stages.sv
`timescale 1ns/1ps
module wdt2_stages
  import wdt2_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter logic [CNT_W-1:0] INIT1 = CNT_W'(512),
  parameter logic [CNT_W-1:0] INIT2 = CNT_W'(512)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] pre1,
  input  logic [CNT_W-1:0] pre2,
  output logic             exp1,
  output logic             exp2
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt1;
  logic [CNT_W-1:0] cnt2;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FIRST;
      cnt1  <= INIT1;
      cnt2  <= INIT2;
      exp1  <= 1'b0;
      exp2  <= 1'b0;
    end else begin
      exp1 <= 1'b0;
      exp2 <= 1'b0;
      if (reload) begin
        phase <= PH_FIRST;
        cnt1  <= pre1;
        cnt2  <= pre2;
      end else if (run && tick) begin
        if (phase == PH_FIRST) begin
          if (cnt1 <= ONE) begin
            phase <= PH_SECOND;
            exp1  <= 1'b1;
          end else begin
            cnt1 <= cnt1 - ONE;
          end
        end else begin
          if (cnt2 <= ONE) begin
            phase <= PH_FIRST;
            cnt1  <= pre1;
            cnt2  <= pre2;
            exp2  <= 1'b1;
          end else begin
            cnt2 <= cnt2 - ONE;
          end
        end
      end
    end
  end

  // R10: disabled stages hold their state
  assert_hold_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    (!run && !reload) |=> ($stable(cnt1) && $stable(cnt2) && $stable(phase)));

  // R6: second-stage expiry only ever follows the second phase
  assert_second_after_first_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(exp2) |-> ($past(phase) == PH_SECOND));
endmodule

// File: rtl/wdt2_pulse.sv
`timescale 1ns/1ps
module wdt2_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic por,
  input  logic fire,
  output logic out
);
  localparam int LW = $clog2(LEN + 1);
  localparam int HW = LW + 2;

  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (por) begin
      out  <= 1'b0;
      left <= '0;
    end else if (fire) begin
      out  <= 1'b1;
      left <= LW'(LEN - 1);
    end else if (left != '0) begin
      left <= left - 1'b1;
    end else begin
      out <= 1'b0;
    end
  end

  // checker-side width counter
  logic [HW-1:0] hi_len;
  always_ff @(posedge clk) begin
    if (por || !out) hi_len <= '0;
    else if (hi_len != '1) hi_len <= hi_len + 1'b1;
  end

  // R6: every pulse ends after exactly LEN cycles
  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (por)
    $fell(out) |-> (hi_len == HW'(LEN)));
endmodule

// File: rtl/wdt_dual_stage.sv
`timescale 1ns/1ps
module wdt_dual_stage
  import wdt2_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 20,
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5,
  parameter int PULSE_LEN = 16,
  parameter int PRE_INIT  = 512
) (
  input  logic              clk,
  input  logic              por,
  input  logic              sys_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  localparam logic [CNT_W-1:0]  PRE_DEF = CNT_W'(PRE_INIT);
  localparam logic [ADDR_W-1:0] A_PRE1  = ADDR_W'(OFS_PRE1);
  localparam logic [ADDR_W-1:0] A_PRE2  = ADDR_W'(OFS_PRE2);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_RLD   = ADDR_W'(OFS_RELOAD);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);

  logic any_rst;
  assign any_rst = por | sys_rst;

  logic unused_hi;
  assign unused_hi = ^wr_data;

  // Key sequencer
  logic key_open;
  wdt2_keyseq #(.ADDR_W(ADDR_W)) u_key (
    .clk    (clk),
    .rst    (any_rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_byte(wr_data[7:0]),
    .open_o (key_open)
  );

  logic prot_wr;
  assign prot_wr = wr_en & key_open;

  // Register file
  logic [CNT_W-1:0] pre1_q, pre2_q;
  logic       cfg_norst, cfg_fast;
  logic [1:0] cfg_itype;
  logic       mode_q, en_q, lock_q;
  logic       stat_q, tof_q;
  logic       reload_cmd, flag_clr;
  logic       exp1, exp2;

  assign reload_cmd = prot_wr && wr_addr == A_RLD && wr_data[RLD_CMD_BIT];
  assign flag_clr   = prot_wr && wr_addr == A_RLD && wr_data[RLD_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (any_rst) begin
      pre1_q <= PRE_DEF;
      pre2_q <= PRE_DEF;
    end else if (prot_wr) begin
      if (wr_addr == A_PRE1) pre1_q <= wr_data[CNT_W-1:0];
      if (wr_addr == A_PRE2) pre2_q <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      cfg_norst <= 1'b0;
      cfg_fast  <= 1'b0;
      cfg_itype <= 2'b00;
    end else if (wr_en && wr_addr == A_CFG) begin
      cfg_norst <= wr_data[CFG_NORST];
      cfg_fast  <= wr_data[CFG_FAST];
      cfg_itype <= wr_data[1:0];
    end
  end

  // Lock and enable: lock is set-only, enable cannot drop while locked
  always_ff @(posedge clk) begin
    if (por) begin
      lock_q <= 1'b0;
      en_q   <= 1'b0;
      mode_q <= 1'b0;
    end else if (sys_rst) begin
      if (!lock_q) begin
        en_q   <= 1'b0;
        mode_q <= 1'b0;
      end
    end else if (wr_en && wr_addr == A_CTRL) begin
      if (wr_data[CTRL_LOCK]) lock_q <= 1'b1;
      en_q <= wr_data[CTRL_EN] | lock_q;
      if (!lock_q) mode_q <= wr_data[CTRL_MODE];
    end
  end

  // Sticky timeout flag, cleared by power-on or keyed write
  always_ff @(posedge clk) begin
    if (por)                  tof_q <= 1'b0;
    else if (exp2 && !mode_q) tof_q <= 1'b1;
    else if (flag_clr)        tof_q <= 1'b0;
  end

  // Interrupt status
  always_ff @(posedge clk) begin
    if (any_rst)                                        stat_q <= 1'b0;
    else if (exp1)                                      stat_q <= 1'b1;
    else if (wr_en && wr_addr == A_STAT && wr_data[0])  stat_q <= 1'b0;
  end

  assign irq_o = stat_q & (cfg_itype != 2'b11);

  // Timebase and stages
  logic tick;
  wdt2_prescale #(.SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2)) u_pre (
    .clk  (clk),
    .rst  (any_rst),
    .run  (en_q),
    .clear(reload_cmd),
    .fast (cfg_fast),
    .tick (tick)
  );

  wdt2_stages #(.CNT_W(CNT_W), .INIT1(PRE_DEF), .INIT2(PRE_DEF)) u_stg (
    .clk   (clk),
    .rst   (any_rst),
    .run   (en_q),
    .tick  (tick),
    .reload(reload_cmd),
    .pre1  (pre1_q),
    .pre2  (pre2_q),
    .exp1  (exp1),
    .exp2  (exp2)
  );

  wdt2_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk (clk),
    .por (por),
    .fire(exp2 && !mode_q && !cfg_norst),
    .out (wdt_rst_o)
  );

  // Registered read port
  always_ff @(posedge clk) begin
    if (any_rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      unique case (rd_addr)
        A_PRE1: rd_data <= DATA_W'(pre1_q);
        A_PRE2: rd_data <= DATA_W'(pre2_q);
        A_STAT: rd_data[0] <= stat_q;
        A_RLD:  rd_data[RLD_FLAG_BIT] <= tof_q;
        A_CFG: begin
          rd_data[CFG_NORST] <= cfg_norst;
          rd_data[CFG_FAST]  <= cfg_fast;
          rd_data[1:0]       <= cfg_itype;
        end
        A_CTRL: begin
          rd_data[CTRL_MODE] <= mode_q;
          rd_data[CTRL_EN]   <= en_q;
          rd_data[CTRL_LOCK] <= lock_q;
        end
        default: rd_data <= '0;
      endcase
    end
  end

  // R9: a locked, running watchdog stays enabled
  assert_lock_holds_R9: assert property (@(posedge clk) disable iff (por)
    (lock_q && en_q) |=> en_q);

  // R8: the timeout flag only drops by an explicit keyed clear
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (por)
    (tof_q && !flag_clr) |=> tof_q);

  // R1: unkeyed writes do not reach the first preload
  assert_unkeyed_ignored_R1: assert property (@(posedge clk) disable iff (any_rst)
    (wr_en && !key_open && wr_addr == A_PRE1) |=> $stable(pre1_q));
endmodule

// File: tb/wdt_dual_stage_test.sv
`timescale 1ns/1ps
module wdt_dual_stage_test;
  localparam int FDIV = 32;
  localparam int SDIV = 32768;
  localparam int PLEN = 16;

  logic        clk = 1'b0;
  logic        por, sys_rst, wr_en;
  logic [7:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        irq_o, wdt_rst_o;

  int nvec = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  wdt_dual_stage uut (
    .clk(clk), .por(por), .sys_rst(sys_rst), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
  );

  typedef struct packed {
    logic        rd;
    logic [7:0]  a;
    logic [31:0] d;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VT [NV] = '{
    '{1'b1, 8'h00, 32'h200, 8'd12},                                   // R12 reset value
    '{1'b0, 8'h00, 32'h5, 8'd1},     '{1'b1, 8'h00, 32'h200, 8'd1},   // R1 unkeyed
    '{1'b0, 8'h0C, 32'h80, 8'd1},    '{1'b0, 8'h0C, 32'h86, 8'd1},
    '{1'b0, 8'h00, 32'h12345, 8'd1}, '{1'b1, 8'h00, 32'h12345, 8'd1}, // R1 keyed
    '{1'b0, 8'h00, 32'h777, 8'd1},   '{1'b1, 8'h00, 32'h12345, 8'd1}, // R1 one shot
    '{1'b0, 8'h0C, 32'h80, 8'd2},    '{1'b0, 8'h10, 32'h0, 8'd2},
    '{1'b0, 8'h0C, 32'h86, 8'd2},    '{1'b0, 8'h04, 32'h55, 8'd2},
    '{1'b1, 8'h04, 32'h200, 8'd2},                                    // R2 foreign addr
    '{1'b0, 8'h0C, 32'h80, 8'd2},    '{1'b0, 8'h0C, 32'h81, 8'd2},
    '{1'b0, 8'h0C, 32'h86, 8'd2},    '{1'b0, 8'h04, 32'h66, 8'd2},
    '{1'b1, 8'h04, 32'h200, 8'd2},                                    // R2 wrong byte
    '{1'b0, 8'h0C, 32'h80, 8'd12},   '{1'b0, 8'h0C, 32'h86, 8'd12},
    '{1'b0, 8'h04, 32'hFFFFFFFF, 8'd12}, '{1'b1, 8'h04, 32'hFFFFF, 8'd12}, // R12 width
    '{1'b0, 8'h14, 32'h4, 8'd11},    '{1'b1, 8'h14, 32'h4, 8'd11},    // R11 mode bit
    '{1'b0, 8'h14, 32'h0, 8'd11},    '{1'b1, 8'h14, 32'h0, 8'd11},
    '{1'b0, 8'h14, 32'h2, 8'd9},     '{1'b1, 8'h14, 32'h2, 8'd9},     // R9 enable unkeyed
    '{1'b0, 8'h14, 32'h0, 8'd9},     '{1'b1, 8'h14, 32'h0, 8'd9},
    '{1'b1, 8'h08, 32'h0, 8'd5},     '{1'b1, 8'h0C, 32'h0, 8'd8},     // R5, R8 idle
    '{1'b0, 8'h10, 32'h27, 8'd4},    '{1'b1, 8'h10, 32'h27, 8'd4},    // R4 cfg
    '{1'b0, 8'h10, 32'hFF, 8'd4},    '{1'b1, 8'h10, 32'h27, 8'd4},
    '{1'b0, 8'h10, 32'h0, 8'd4}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic kwr(input logic [7:0] a, input logic [31:0] d);
    wr(8'h0C, 32'h80);
    wr(8'h0C, 32'h86);
    wr(a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic arm(input int n1, input int n2, input logic [31:0] cfg);
    wr(8'h10, cfg);
    wr(8'h08, 32'h1);
    kwr(8'h00, n1);
    kwr(8'h04, n2);
    kwr(8'h0C, 32'h100);
  endtask

  // counts clocks from the current negedge until the chosen output is high
  task automatic wait_hi(input bit pick_rst, input int limit, output int n);
    n = 0;
    while (!(pick_rst ? wdt_rst_o : irq_o) && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_rst(input bit power);
    @(negedge clk);
    if (power) por = 1'b1; else sys_rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    por = 1'b0; sys_rst = 1'b0;
  endtask

  // watchdog on the bench itself
  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: bench hung");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, w;
    bit seen;
    por = 1'b1; sys_rst = 1'b1; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    por = 1'b0; sys_rst = 1'b0;
    @(negedge clk);
    chk("R5 reset irq", {31'd0, irq_o}, 32'd0);
    chk("R6 reset pulse", {31'd0, wdt_rst_o}, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VT[i].rd) begin
        rd(VT[i].a, v);
        chk($sformatf("R%0d table row %0d", VT[i].req, i), v, VT[i].d);
      end else begin
        wr(VT[i].a, VT[i].d);
      end
    end

    // R4 R5 R6 R8: fast tick, full two-stage expiry
    arm(3, 2, 32'h04);
    wr(8'h14, 32'h2);
    wait_hi(1'b0, 2000, n);
    chk("R4/R5 irq latency", n, FDIV * 3 + 1);
    wait_hi(1'b1, 2000, w);
    chk("R6 reset latency", n + w, FDIV * 5 + 1);
    w = 0;
    while (wdt_rst_o && w < 100) begin @(negedge clk); w++; end
    chk("R6 pulse width", w, PLEN);
    wr(8'h14, 32'h0);
    rd(8'h0C, v); chk("R6 flag set", v, 32'h200);
    rd(8'h08, v); chk("R5 status", v, 32'h1);
    wr(8'h08, 32'h1);
    chk("R5 irq cleared", {31'd0, irq_o}, 32'd0);
    wr(8'h0C, 32'h200);
    rd(8'h0C, v); chk("R8 unkeyed clear ignored", v, 32'h200);
    kwr(8'h0C, 32'h200);
    rd(8'h0C, v); chk("R8 keyed clear", v, 32'h0);

    // R5: interrupt type 11 masks the pin, status still set
    arm(3, 9, 32'h07);
    wr(8'h14, 32'h2);
    seen = 0;
    for (int k = 0; k < FDIV * 3 + 10; k++) begin @(negedge clk); if (irq_o) seen = 1; end
    wr(8'h14, 32'h0);
    chk("R5 masked irq", {31'd0, seen}, 32'd0);
    rd(8'h08, v); chk("R5 masked status", v, 32'h1);

    // R7 R8: reset output gated, flag still set and survives sys_rst
    arm(3, 2, 32'h24);
    wr(8'h14, 32'h2);
    seen = 0;
    for (int k = 0; k < FDIV * 5 + 20; k++) begin @(negedge clk); if (wdt_rst_o) seen = 1; end
    wr(8'h14, 32'h0);
    chk("R7 no pulse", {31'd0, seen}, 32'd0);
    rd(8'h0C, v); chk("R7 flag set", v, 32'h200);
    pulse_rst(1'b0);
    rd(8'h0C, v); chk("R8 flag survives sys_rst", v, 32'h200);
    rd(8'h00, v); chk("R12 preload after sys_rst", v, 32'h200);
    kwr(8'h0C, 32'h200);

    // R11: timer mode
    arm(3, 2, 32'h04);
    wr(8'h14, 32'h6);
    seen = 0;
    for (int k = 0; k < FDIV * 5 + 20; k++) begin @(negedge clk); if (wdt_rst_o) seen = 1; end
    chk("R11 irq in timer mode", {31'd0, irq_o}, 32'd1);
    wr(8'h14, 32'h0);
    chk("R11 no pulse", {31'd0, seen}, 32'd0);
    rd(8'h0C, v); chk("R11 no flag", v, 32'h0);

    // R3: reload mid-count restarts the first stage
    arm(3, 2, 32'h04);
    wr(8'h14, 32'h2);
    repeat (80) @(negedge clk);
    kwr(8'h0C, 32'h100);
    wait_hi(1'b0, 2000, n);
    chk("R3 restart latency", n, FDIV * 3 + 1);
    wr(8'h14, 32'h0);

    // R10: disable holds counts and drops the partial tick
    arm(3, 2, 32'h04);
    wr(8'h14, 32'h2);
    repeat (50) @(negedge clk);
    wr(8'h14, 32'h0);
    seen = 0;
    for (int k = 0; k < 200; k++) begin @(negedge clk); if (irq_o) seen = 1; end
    chk("R10 no expiry while disabled", {31'd0, seen}, 32'd0);
    wr(8'h14, 32'h2);
    wait_hi(1'b0, 2000, n);
    chk("R10 resumed latency", n, FDIV * 2 + 1);
    wr(8'h14, 32'h0);

    // R4: slow tick
    arm(1, 5, 32'h00);
    wr(8'h14, 32'h2);
    wait_hi(1'b0, 40000, n);
    chk("R4 slow tick", n, SDIV + 1);
    wr(8'h14, 32'h0);

    // R9: lock
    wr(8'h14, 32'h3);
    wr(8'h14, 32'h0);
    rd(8'h14, v); chk("R9 disable refused", v, 32'h3);
    pulse_rst(1'b0);
    rd(8'h14, v); chk("R9 lock survives sys_rst", v, 32'h3);
    pulse_rst(1'b1);
    rd(8'h14, v); chk("R9 por clears lock", v, 32'h0);
    rd(8'h00, v); chk("R12 preload after por", v, 32'h200);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule